// File: doc/BRIEF.md
# Serial Byte Receiver with Four-Entry Buffer

This block is the receive half of an 8N1 asynchronous serial port. A free-running divider turns the system clock into a sampling tick that fires four times per bit period. The incoming line passes through a two-flop synchroniser. A small state machine then finds the start bit, confirms it, takes eight data bits least-significant first and checks the stop bit.

Each finished byte goes into a four-entry first-in first-out buffer. The oldest entry is always visible on the data output, and a pop strobe removes it. Status outputs show whether the buffer is empty, full, or has one free slot left. Two sticky error flags report a bad stop bit and a byte lost to a full buffer. A register front-end clears each flag with its own strobe.

Top module: `uart_rx_fifo`

## Requirements
- R1: The sampling tick fires once every D+1 clocks for divisor D. Four ticks make one bit, so a frame sent with a bit time of 4*(D+1) clocks is received correctly for any divisor.
- R2: The frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. `data_o` shows the oldest stored byte, and `pop_i` removes it, so bytes come out in arrival order.
- R3: A start bit is accepted only if the line is still low two ticks after the low level was first seen. A shorter low pulse stores nothing.
- R4: The buffer holds four bytes. `empty_o` is high with zero entries, `one_left_o` is high with exactly three entries, and `full_o` is high with four. A push and a pop in the same cycle leave the entry count unchanged.
- R5: A byte that completes while the buffer is full is dropped and sets `overrun_err_o`. The four stored bytes and their order are kept.
- R6: A stop-bit sample that is low sets `frame_err_o`. The byte is still stored.
- R7: Each error flag stays set until its own clear strobe (`clr_frame_i` or `clr_overrun_i`). Clearing one flag leaves the other unchanged.
- R8: After a frame, the receiver waits for the line to be high before it looks for a new start bit. A line held low after a bad stop bit yields no further bytes.
- R9: A pop while the buffer is empty has no effect. The buffer stays empty, and the next received byte is stored and read normally.
- R10: After reset the buffer is empty, `full_o` and `one_left_o` are low, and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| divisor_i | input | 16 | Tick divisor D; the tick period is D+1 clocks |
| rx_i | input | 1 | Asynchronous serial input line |
| pop_i | input | 1 | Removes the oldest byte from the buffer |
| clr_frame_i | input | 1 | Clears the frame error flag |
| clr_overrun_i | input | 1 | Clears the overrun flag |
| data_o | output | 8 | Oldest stored byte |
| empty_o | output | 1 | Buffer holds no byte |
| full_o | output | 1 | Buffer holds four bytes |
| one_left_o | output | 1 | Exactly one free entry remains |
| frame_err_o | output | 1 | Sticky flag: a stop bit was sampled low |
| overrun_err_o | output | 1 | Sticky flag: a byte was dropped on a full buffer |

## Verification
The assertions check the following on every cycle:
- the entry count never exceeds four;
- a simultaneous push and pop leaves the count alone;
- an overrun changes neither the count nor the head byte;
- a pop on an empty buffer changes nothing;
- both error flags hold until they are cleared;
- nothing is pushed while the receiver waits for the line to return high.

Only the bench scenarios can show the following:
- bit order and divisor timing, by sending whole frames at two divisors;
- rejection of a short start pulse;
- the status flag sequence as the buffer fills;
- arrival order after an overrun;
- single-byte behaviour when the line is held low after a bad stop bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned TICKS_PER_BIT = 4;
  localparam int unsigned TCW = $clog2(TICKS_PER_BIT);

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_e;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= guards against a divisor lowered below the running count
  assign tick_o = (cnt_q >= divisor_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r1_tick_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o || (divisor_i == '0));
endmodule

// File: rtl/rx_sampler.sv
module rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              push_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              ferr_o
);
  localparam int unsigned BCW = $clog2(DATA_W);

  logic              sync1_q, rx_s;
  rx_state_e         state_q;
  logic [TCW-1:0]    tcnt_q;
  logic [BCW-1:0]    bcnt_q;
  logic [DATA_W-1:0] shift_q;
  logic              mid_tick, end_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      sync1_q <= rx_i;
      rx_s    <= sync1_q;
    end
  end

  // window positions 0..3; sample on the tick that reaches position 2
  assign mid_tick = tick_i && (tcnt_q == TCW'(TICKS_PER_BIT/2 - 1));
  assign end_tick = tick_i && (tcnt_q == TCW'(TICKS_PER_BIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shift_q <= '0;
      push_o  <= 1'b0;
      byte_o  <= '0;
      ferr_o  <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (tick_i && state_q != RX_IDLE && state_q != RX_WAIT_HIGH)
        tcnt_q <= tcnt_q + 1'b1;
      unique case (state_q)
        RX_IDLE: begin
          if (tick_i && !rx_s) begin
            state_q <= RX_START;
            tcnt_q  <= '0;
          end
        end
        RX_START: begin
          if (mid_tick && rx_s) state_q <= RX_IDLE;
          else if (end_tick) begin
            state_q <= RX_DATA;
            bcnt_q  <= '0;
          end
        end
        RX_DATA: begin
          if (mid_tick) shift_q <= {rx_s, shift_q[DATA_W-1:1]};
          if (end_tick) begin
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == BCW'(DATA_W - 1)) state_q <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (mid_tick) begin
            push_o  <= 1'b1;
            byte_o  <= shift_q;
            ferr_o  <= !rx_s;
            state_q <= rx_s ? RX_IDLE : RX_WAIT_HIGH;
          end
        end
        RX_WAIT_HIGH: begin
          if (rx_s) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  a_r8_no_push_while_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_WAIT_HIGH) |=> !push_o);
  a_r6_ferr_with_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && ferr_o) |-> (state_q == RX_WAIT_HIGH || state_q == RX_IDLE));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              one_left_o,
  output logic              ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == CW'(DEPTH));
  assign one_left_o = (cnt_q == CW'(DEPTH - 1));
  assign do_push    = push_i && !full_o;
  assign do_pop     = pop_i && !empty_o;
  assign ovf_o      = push_i && full_o;
  assign rdata_o    = mem_q[rptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wptr_q] <= wdata_i;
        wptr_q        <= nxt(wptr_q);
      end
      if (do_pop) rptr_q <= nxt(rptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r4_push_pop_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty_o && !full_o) |=> $stable(cnt_q));
  a_r5_overrun_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (full_o && $stable(rdata_o)));
  a_r9_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> (empty_o && $stable(rptr_q)));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              rx_i,
  input  logic              pop_i,
  input  logic              clr_frame_i,
  input  logic              clr_overrun_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              one_left_o,
  output logic              frame_err_o,
  output logic              overrun_err_o
);
  logic              tick;
  logic              push, ferr, ovf;
  logic [DATA_W-1:0] rx_byte;

  rx_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk_i, .rst_ni, .divisor_i, .tick_o(tick)
  );

  rx_sampler #(.DATA_W(DATA_W)) i_sampler (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i,
    .push_o(push), .byte_o(rx_byte), .ferr_o(ferr)
  );

  rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(rx_byte), .pop_i,
    .rdata_o(data_o), .empty_o, .full_o, .one_left_o, .ovf_o(ovf)
  );

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_err_o   <= 1'b0;
      overrun_err_o <= 1'b0;
    end else begin
      if (push && ferr)       frame_err_o <= 1'b1;
      else if (clr_frame_i)   frame_err_o <= 1'b0;
      if (ovf)                overrun_err_o <= 1'b1;
      else if (clr_overrun_i) overrun_err_o <= 1'b0;
    end
  end

  a_r7_frame_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_err_o && !clr_frame_i) |=> frame_err_o);
  a_r7_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_err_o && !clr_overrun_i) |=> overrun_err_o);
endmodule

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd3;
  logic        rx = 1'b1;
  logic        pop = 1'b0, clr_f = 1'b0, clr_o = 1'b0;
  logic [7:0]  data;
  logic        empty, full, one_left, ferr, oerr;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  uart_rx_fifo i_uart_rx_fifo (
    .clk_i(clk), .rst_ni(rst_n), .divisor_i(divisor), .rx_i(rx),
    .pop_i(pop), .clr_frame_i(clr_f), .clr_overrun_i(clr_o),
    .data_o(data), .empty_o(empty), .full_o(full), .one_left_o(one_left),
    .frame_err_o(ferr), .overrun_err_o(oerr)
  );

  // {divisor, byte, stop level}
  localparam int NV = 6;
  localparam logic [24:0] VEC [NV] = '{
    {16'd3, 8'hA5, 1'b1}, {16'd3, 8'h01, 1'b1}, {16'd5, 8'h80, 1'b1},
    {16'd5, 8'h5A, 1'b0}, {16'd3, 8'hFF, 1'b1}, {16'd5, 8'h00, 1'b1}
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(int bits);
    repeat (bits * 4 * (divisor + 1)) @(negedge clk);
  endtask

  task automatic send(logic [7:0] b, logic stop_lvl, int idle_bits);
    rx = 1'b0; hold(1);
    for (int i = 0; i < 8; i++) begin rx = b[i]; hold(1); end
    rx = stop_lvl; hold(1);
    rx = 1'b1; hold(idle_bits);
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 empty", empty, 1); chk("R10 full", full, 0);
    chk("R10 one_left", one_left, 0);
    chk("R10 ferr", ferr, 0); chk("R10 oerr", oerr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      divisor = VEC[v][24:9];
      hold(2);
      send(VEC[v][8:1], VEC[v][0], 2);
      chk("R1 byte present", empty, 0);
      chk("R2 data", data, VEC[v][8:1]);
      chk("R6 frame flag", ferr, !VEC[v][0]);
      strobe(pop);
      chk("R2 popped", empty, 1);
      strobe(clr_f);
    end

    divisor = 16'd3; hold(2);
    // R3: low pulse of one tick period
    rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1; hold(14);
    chk("R3 glitch rejected", empty, 1);

    send(8'h11, 1, 2); send(8'h22, 1, 2); send(8'h33, 1, 2);
    chk("R4 one_left at 3", one_left, 1); chk("R4 not full at 3", full, 0);
    send(8'h44, 1, 2);
    chk("R4 full at 4", full, 1); chk("R4 one_left off", one_left, 0);
    send(8'h55, 1, 2);
    chk("R5 overrun", oerr, 1); chk("R5 still full", full, 1);
    chk("R5 head kept", data, 8'h11);
    for (int k = 0; k < 4; k++) begin
      chk("R2 order", data, 8'h11 * (k + 1));
      strobe(pop);
    end
    chk("R5 dropped byte gone", empty, 1);

    send(8'h6C, 0, 2);
    chk("R6 stored", data, 8'h6C); chk("R6 flag", ferr, 1);
    strobe(clr_o);
    chk("R7 overrun cleared", oerr, 0); chk("R7 frame kept", ferr, 1);
    hold(3);
    chk("R7 frame still", ferr, 1);
    strobe(clr_f);
    chk("R7 frame cleared", ferr, 0);
    strobe(pop);

    // R8: bad stop bit, line held low
    rx = 1'b0; hold(1);
    for (int i = 0; i < 8; i++) begin rx = 1'b0; hold(1); end
    hold(12);
    rx = 1'b1; hold(3);
    chk("R8 one byte", data, 8'h00); chk("R8 not empty", empty, 0);
    strobe(pop);
    chk("R8 no extra byte", empty, 1);
    strobe(clr_f);

    strobe(pop); strobe(pop);
    chk("R9 still empty", empty, 1); chk("R9 not full", full, 0);
    send(8'h3C, 1, 2);
    chk("R9 next byte", data, 8'h3C);
    strobe(pop);
    chk("R9 single entry", empty, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule